// File: doc/BRIEF.md
# Receive Descriptor-Ring DMA Engine

This block takes received Ethernet frames from a byte stream and stores them in memory buffers. The buffers are described by a ring of descriptors that software places in memory. Software loads the ring base address and picks a descriptor size of 16, 32 or 64 bytes. It then pulses `start`. The engine reads three words from each descriptor:

- word 0 holds ownership and list control,
- word 1 holds the buffer length,
- word 2 holds the buffer address.

The engine then fills the buffer with frame bytes, packed into 32-bit words.

A frame that does not fit in one buffer carries on in the buffer of the next descriptor. When a buffer is closed, the engine writes status back into the first two words of its descriptor. This clears ownership, records where the buffer sits within its frame, flags errors and stores the byte count. If the engine finds a descriptor it does not own, it stops. While stopped it discards incoming bytes until software starts it again.

The memory side is a single 32-bit master. It holds a request until that request is acknowledged. Read data is taken in the cycle that carries the acknowledge.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset, `run` is low and no memory access is made. A pulse on `start` raises `run` and starts the first read at the word-0 address of `ring_base`.
- R2: A word 0 that is fetched with bit 31 clear stops the engine and drops `run`. While stopped, `in_ready` is high, and accepted bytes are discarded with no memory write.
- R3: The next descriptor address is the current one plus 16, 32 or 64 bytes, for `desc_size` 0, 1 or 2 (a value of 3 also gives 64).
- R4: Word 1 bits 31:16 hold the buffer length in bytes, which must be nonzero. Word 2 holds the word-aligned buffer address. Data is written to consecutive words from that address, and each write request stays stable until acknowledged.
- R5: At most the buffer length is stored in one buffer. The bytes of a frame that remain continue at the start of the next descriptor's buffer.
- R6: After a descriptor whose word 0 bit 30 is set, the next fetch is at `ring_base`.
- R7: Written-back word 0 has bit 31 cleared, bit 30 kept as fetched and bits 26:0 zero.
- R8: Written-back word 0 bits 29:28 give the buffer's place in the frame: 11 for a whole frame, 10 for the first buffer, 00 for a middle buffer and 01 for the last buffer. Bit 27 is set if `in_err` accompanied any byte stored in that buffer.
- R9: Written-back word 1 holds the buffer length in bits 31:16 and the number of bytes stored in bits 15:0.
- R10: Byte n of a buffer goes to bits 8*(n mod 4)+7 down to 8*(n mod 4) of word n/4. In a final partial word, the unused upper bytes are written as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that starts reception at the ring base |
| ring_base | input | 32 | Byte address of the first descriptor |
| desc_size | input | 2 | Descriptor stride select: 0=16, 1=32, 2/3=64 bytes |
| run | output | 1 | High while reception is enabled |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_err | input | 1 | Error reported with this byte |
| in_ready | output | 1 | Engine takes the byte on this clock edge |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completes on this edge |

## Verification
A descriptor fetch costs three memory round trips. Each stored word costs one round trip after the byte that fills it, and a write-back costs two more. With the bench memory answering one cycle after a request, a buffer's data and status are therefore in memory within about a dozen cycles of its last byte. The bench waits well over that margin (30 cycles or more) after the last byte of a frame before it reads the model memory. It also samples `run` only after the next descriptor fetch has finished, so each check sees settled results and not a transition in progress. Address order is observed through a monitor on the memory port that records the last read address and counts writes. In this way stride, wrap-around and the absence of writes are all checked at the ports.

// File: rtl/rx_ring_dma.sv
`timescale 1ns/1ps
module rx_ring_dma #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] ring_base,
  input  logic [1:0]    desc_size,
  output logic          run,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          in_err,
  output logic          in_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack
);
  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_RD2, S_RECV, S_WRD, S_WB0, S_WB1} st_t;
  st_t st;

  logic [AW-1:0] desc_addr, buf_ptr, stride;
  logic [LW-1:0] buf_len, cnt;
  logic [31:0]   pack;
  logic last_f, in_frame, began, eof_seen, err_f;
  logic take, full_next, flush;

  assign stride   = (desc_size == 2'd0) ? AW'(16) : (desc_size == 2'd1) ? AW'(32) : AW'(64);
  assign run      = (st != S_IDLE);
  assign in_ready = (st == S_IDLE) || (st == S_RECV);
  assign take     = (st == S_RECV) && in_valid && (in_frame || in_sof);
  assign full_next = (LW'(cnt + LW'(1)) == buf_len);
  assign flush    = (cnt[1:0] == 2'd3) || in_eof || full_next;

  assign mem_req = (st == S_RD0) || (st == S_RD1) || (st == S_RD2) ||
                   (st == S_WRD) || (st == S_WB0) || (st == S_WB1);
  assign mem_we  = (st == S_WRD) || (st == S_WB0) || (st == S_WB1);

  always_comb begin
    mem_addr  = desc_addr;
    mem_wdata = '0;
    case (st)
      S_RD1:   mem_addr = desc_addr + AW'(4);
      S_RD2:   mem_addr = desc_addr + AW'(8);
      S_WRD: begin
        mem_addr  = buf_ptr;
        mem_wdata = pack;
      end
      S_WB0:   mem_wdata = {1'b0, last_f, began, eof_seen, err_f, 27'd0};
      S_WB1: begin
        mem_addr  = desc_addr + AW'(4);
        mem_wdata = {buf_len, cnt};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      desc_addr <= '0;
      buf_ptr   <= '0;
      buf_len   <= '0;
      cnt       <= '0;
      pack      <= '0;
      last_f    <= 1'b0;
      in_frame  <= 1'b0;
      began     <= 1'b0;
      eof_seen  <= 1'b0;
      err_f     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          desc_addr <= ring_base;
          st        <= S_RD0;
        end
        S_RD0: if (mem_ack) begin
          if (!mem_rdata[31]) begin
            in_frame <= 1'b0;
            st       <= S_IDLE;
          end else begin
            last_f <= mem_rdata[30];
            st     <= S_RD1;
          end
        end
        S_RD1: if (mem_ack) begin
          buf_len <= mem_rdata[31:16];
          st      <= S_RD2;
        end
        S_RD2: if (mem_ack) begin
          buf_ptr  <= mem_rdata[AW-1:0];
          cnt      <= '0;
          pack     <= '0;
          began    <= 1'b0;
          eof_seen <= 1'b0;
          err_f    <= 1'b0;
          st       <= S_RECV;
        end
        S_RECV: if (take) begin
          pack[{cnt[1:0], 3'b000} +: 8] <= in_data;
          cnt      <= LW'(cnt + LW'(1));
          in_frame <= 1'b1;
          if (in_sof && !in_frame) began <= 1'b1;
          if (in_err) err_f <= 1'b1;
          eof_seen <= in_eof;
          if (flush) st <= S_WRD;
        end
        S_WRD: if (mem_ack) begin
          pack    <= '0;
          buf_ptr <= buf_ptr + AW'(4);
          st      <= (eof_seen || cnt == buf_len) ? S_WB0 : S_RECV;
        end
        S_WB0: if (mem_ack) st <= S_WB1;
        S_WB1: if (mem_ack) begin
          desc_addr <= last_f ? ring_base : desc_addr + stride;
          if (eof_seen) in_frame <= 1'b0;
          st <= S_RD0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start) |=> !mem_req); // R1
  AST_STOP_ON_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD0 && mem_ack && !mem_rdata[31]) |=> !run); // R2
  AST_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB1 && mem_ack && !last_f) |=> desc_addr == $past(desc_addr) + $past(stride)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R4
  AST_BUF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RECV) |-> cnt < buf_len); // R5
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB1 && mem_ack && last_f) |=> desc_addr == $past(ring_base)); // R6
endmodule

// File: tb/tb_rx_ring_dma.sv
`timescale 1ns/1ps
module tb_rx_ring_dma;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, in_valid = 0, in_sof = 0, in_eof = 0, in_err = 0;
  logic [7:0] in_data = 0;
  logic [31:0] ring_base = 0;
  logic [1:0] desc_size = 0;
  logic run, in_ready, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  rx_ring_dma dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ring_base(ring_base), .desc_size(desc_size),
    .run(run), .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_err(in_err), .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  logic [31:0] mem [0:1023];
  int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0;
  logic [31:0] last_rd = 0;
  logic ack_r = 0;
  logic [31:0] rdata_r = 0;
  assign mem_ack = ack_r;
  assign mem_rdata = rdata_r;

  always @(posedge clk) begin
    if (mem_req && !ack_r) begin
      ack_r <= 1'b1;
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      rdata_r <= mem[mem_addr[11:2]];
    end else ack_r <= 1'b0;
    if (mem_req && ack_r) begin
      if (mem_we) n_wr <= n_wr + 1;
      else begin
        n_rd <= n_rd + 1;
        last_rd <= mem_addr;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int s, input int n, input int k);
    logic [31:0] w = 0;
    for (int b = 0; b < 4; b++)
      if (4*k + b < n) w[8*b +: 8] = 8'(s + 4*k + b);
    return w;
  endfunction

  task automatic put_desc(input int a, input logic [31:0] w0, input int len, input int buf_a);
    mem[a/4]     = w0;
    mem[a/4 + 1] = {16'(len), 16'd0};
    mem[a/4 + 2] = 32'(buf_a);
  endtask

  task automatic send_frame(input int s, input int n, input bit err_last);
    for (int i = 0; i < n; i++) begin
      logic rdy;
      @(negedge clk);
      in_valid = 1; in_data = 8'(s + i);
      in_sof = (i == 0); in_eof = (i == n - 1); in_err = err_last && (i == n - 1);
      forever begin
        rdy = in_ready;
        @(posedge clk);
        if (rdy) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; in_err = 0;
  endtask

  task automatic kick(input logic [31:0] base, input logic [1:0] sz);
    @(negedge clk);
    ring_base = base; desc_size = sz; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 run low after reset", 32'(run), 0);
    chk("R1 no request after reset", 32'(mem_req), 0);
    repeat (20) @(negedge clk);
    chk("R1 no reads before start", 32'(n_rd), 0);
  endtask

  task automatic t_single;
    kick(32'h100, 2'd0);
    repeat (12) @(negedge clk);
    chk("R1 run high after start", 32'(run), 1);
    chk("R1 first fetch word2 of base", last_rd, 32'h108);
    send_frame(8'h10, 10, 0);
    repeat (30) @(negedge clk);
    for (int k = 0; k < 3; k++) chk("R10 packed word", mem['h400/4 + k], exp_word(8'h10, 10, k));
    chk("R7 R8 single-buffer status", mem['h100/4], 32'h3000_0000);
    chk("R9 stored count", mem['h100/4 + 1], 32'h0040_000A);
  endtask

  task automatic t_split_wrap;
    send_frame(8'h40, 20, 1);
    repeat (40) @(negedge clk);
    for (int k = 0; k < 4; k++) chk("R5 first buffer data", mem['h500/4 + k], exp_word(8'h40, 14, k));
    for (int k = 0; k < 2; k++) chk("R5 continuation data", mem['h600/4 + k], exp_word(8'h4E, 6, k));
    chk("R8 first-buffer status", mem['h110/4], 32'h2000_0000);
    chk("R9 full buffer count", mem['h110/4 + 1], 32'h000E_000E);
    chk("R8 R7 last-buffer status with error", mem['h120/4], 32'h5800_0000);
    chk("R9 tail count", mem['h120/4 + 1], 32'h0040_0006);
    chk("R6 wrap fetch at base", last_rd, 32'h100);
    chk("R2 stopped on invalid", 32'(run), 0);
  endtask

  task automatic t_drop;
    int w0 = n_wr;
    send_frame(8'h80, 8, 0);
    repeat (20) @(negedge clk);
    chk("R2 no writes while stopped", 32'(n_wr), 32'(w0));
    chk("R2 buffer untouched", mem['h700/4], 0);
    chk("R2 in_ready high while stopped", 32'(in_ready), 1);
  endtask

  task automatic t_stride32;
    put_desc('h800, 32'h8000_0000, 4, 'hA00);
    put_desc('h820, 32'hC000_0000, 64, 'hB00);
    put_desc('h840, 32'h8000_0000, 64, 'h700);
    kick(32'h800, 2'd1);
    send_frame(8'h60, 6, 0);
    repeat (40) @(negedge clk);
    chk("R4 exact-fill buffer data", mem['hA00/4], 32'h6362_6160);
    chk("R9 exact-fill count", mem['h800/4 + 1], 32'h0004_0004);
    chk("R3 stride 32 status", mem['h820/4], 32'h5000_0000);
    chk("R4 second buffer data", mem['hB00/4], 32'h0000_6564);
    chk("R6 wrap after stride 32", last_rd, 32'h800);
  endtask

  task automatic t_stride64;
    put_desc('hC00, 32'h8000_0000, 64, 'hD00);
    mem['hC40/4] = 0;
    kick(32'hC00, 2'd2);
    send_frame(8'h70, 3, 0);
    repeat (30) @(negedge clk);
    chk("R10 three-byte word", mem['hD00/4], 32'h0072_7170);
    chk("R3 stride 64 next fetch", last_rd, 32'hC40);
    chk("R2 stop after stride 64", 32'(run), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    put_desc('h100, 32'h8000_0000, 64, 'h400);
    put_desc('h110, 32'h8000_0000, 14, 'h500);
    put_desc('h120, 32'hC000_0000, 64, 'h600);
    put_desc('h130, 32'h8000_0000, 64, 'h700);
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_split_wrap();
    t_drop();
    t_stride32();
    t_stride64();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule